// File: doc/BRIEF.md
# Stereo I2S Master Transmitter

This block drives a stereo DAC as the master of an I2S link. It divides the system clock into a master clock and a bit clock. It drives the word-select line and shifts the serial data out. One parameter, `CLKS_PER_BIT`, sets all of the timing: it gives the number of system clocks in one bit period. Each channel takes a 32-bit slot and a frame carries two slots, so the sample rate is sysclk / (64 × `CLKS_PER_BIT`). For example, 160 MHz with 64 clocks per bit gives 39.0625 kHz.

Samples come in as left/right pairs over a valid/ready handshake and wait in a one-pair holding register. At the start of every frame the held pair, if there is one, becomes the pair being sent. If no pair is held, the previous pair is sent again. A one-cycle pulse marks each frame start, and the producer can use it as the cue for the next pair. While `enable` is low, every line is held low and the counters stay at zero. When `enable` rises, the master clock and the bit clock start together from the start of a full bit period.

Top module: `i2s_master_tx`

## Requirements
- R1: `bclk` has a period of `CLKS_PER_BIT` system clocks. It is low for the first half of each bit period and high for the second half. The first bit period after `enable` rises is full length.
- R2: `mclk` toggles every `CLKS_PER_BIT`/8 system clocks, which makes it 4× the `bclk` rate. It starts low in the same cycle as `bclk`.
- R3: `lrclk` is 0 for the 32 bit periods of the left slot and 1 for the 32 of the right slot. It changes only in the cycle where `bclk` falls.
- R4: Within a slot, bit period p (counted from 0) carries sample bit 24−p for p = 1..24. The MSB is therefore sent one bit period after the `lrclk` edge.
- R5: Bit period 0 of each slot and bit periods 25..31 carry 0.
- R6: `dout` changes only in the cycle where `bclk` falls.
- R7: `frame_req` is high for exactly one system clock, at the first falling `bclk` of each left slot.
- R8: `s_ready` is high whenever the holding register is empty. A pair is taken in any cycle with `s_valid` and `s_ready` both high.
- R9: At each frame start, a held pair becomes the transmitted pair and the holding register empties. With no held pair, the previous pair is sent again.
- R10: If a pair is offered in the cycle where a full holding register is emptied at a frame start, `s_ready` is high in that cycle. The old held pair goes out in that frame and the new pair is held for the next one.
- R11: Under reset or while `enable` is low, `mclk`, `bclk`, `lrclk`, `dout` and `frame_req` are 0. After reset `s_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the link; low stops and clears the timing |
| s_valid | input | 1 | A sample pair is offered |
| s_left | input | SAMPLE_W | Left-channel sample |
| s_right | input | SAMPLE_W | Right-channel sample |
| s_ready | output | 1 | The holding register can take a pair this cycle |
| mclk | output | 1 | Master clock, 4× the bit clock |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Word select, 0 = left, 1 = right |
| dout | output | 1 | Serial data, MSB first |
| frame_req | output | 1 | One-cycle pulse at each frame start |

## Verification
The two functions that can fall in the same cycle are the frame-start load of the holding register and the acceptance of a new pair from the producer. The bench provokes this by offering a second pair while the register still holds the first. The offer then stalls until the frame-start cycle, where the load and the acceptance coincide. A behavioural model predicts which pair appears on `dout` in each of the following two frames and compares it bit by bit. It also counts how many times the coincidence occurred, and that count must not be zero.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
   localparam int SLOTS_PER_FRAME = 2;

   typedef enum logic {
      CH_LEFT  = 1'b0,
      CH_RIGHT = 1'b1
   } chan_e;

   function automatic int log2_up(input int v);
      int r;
      r = 0;
      while ((1 << r) < v) r++;
      return (r < 1) ? 1 : r;
   endfunction
endpackage

// File: rtl/i2s_clkgen.sv
module i2s_clkgen
   import i2s_tx_pkg::*;
#(
   parameter int CLKS_PER_BIT = 64,
   parameter int SLOT_W       = 32,
   localparam int PHW         = log2_up(CLKS_PER_BIT),
   localparam int BW          = log2_up(SLOTS_PER_FRAME * SLOT_W)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           enable,
   output logic           run,
   output logic [PHW-1:0] phase,
   output logic [BW-1:0]  bit_idx,
   output logic           frame_start,
   output logic           bclk_n,
   output logic           mclk_n
);
   localparam int MDIV              = CLKS_PER_BIT / 8;
   localparam logic [PHW-1:0] PH_MAX  = PHW'(CLKS_PER_BIT - 1);
   localparam logic [PHW-1:0] PH_HALF = PHW'(CLKS_PER_BIT / 2);
   localparam logic [BW-1:0]  BIT_MAX = BW'(SLOTS_PER_FRAME * SLOT_W - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run     <= 1'b0;
         phase   <= '0;
         bit_idx <= '0;
      end else begin
         run <= enable;
         if (run && enable) begin
            if (phase == PH_MAX) begin
               phase   <= '0;
               bit_idx <= (bit_idx == BIT_MAX) ? '0 : bit_idx + 1'b1;
            end else begin
               phase <= phase + 1'b1;
            end
         end else begin
            phase   <= '0;
            bit_idx <= '0;
         end
      end
   end

   assign frame_start = run && (phase == '0) && (bit_idx == '0);
   assign bclk_n      = (phase >= PH_HALF);

   generate
      if ((MDIV & (MDIV - 1)) == 0) begin : g_mclk_pow2
         localparam int MB = (MDIV == 1) ? 0 : log2_up(MDIV);
         assign mclk_n = phase[MB];
      end else begin : g_mclk_div
         always_comb begin
            mclk_n = (((int'(phase)) / MDIV) % 2) == 1;
         end
      end
   endgenerate

   p_start_full_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> (phase == '0) && (bit_idx == '0));

   p_bit_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && enable && $past(enable) && $past(phase) == PH_MAX && $past(bit_idx) != BIT_MAX)
      |-> bit_idx == $past(bit_idx) + 1'b1);
endmodule

// File: rtl/i2s_sample_hold.sv
module i2s_sample_hold #(
   parameter int SAMPLE_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                s_valid,
   input  logic [SAMPLE_W-1:0] s_left,
   input  logic [SAMPLE_W-1:0] s_right,
   output logic                s_ready,
   output logic [SAMPLE_W-1:0] act_left,
   output logic [SAMPLE_W-1:0] act_right
);
   logic                pend;
   logic [SAMPLE_W-1:0] hold_l;
   logic [SAMPLE_W-1:0] hold_r;
   logic                accept;

   assign s_ready = !pend || load;
   assign accept  = s_valid && s_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         hold_l    <= '0;
         hold_r    <= '0;
         act_left  <= '0;
         act_right <= '0;
      end else begin
         if (load && pend) begin
            act_left  <= hold_l;
            act_right <= hold_r;
         end
         if (accept) begin
            hold_l <= s_left;
            hold_r <= s_right;
         end
         pend <= accept || (pend && !load);
      end
   end

   p_accept_fills_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready) |=> pend);

   p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !load) |=> $stable(hold_l) && $stable(hold_r));

   p_collide_keeps_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && load && s_valid) |=> pend && act_left == $past(hold_l) && hold_l == $past(s_left));
endmodule

// File: rtl/i2s_slot_mux.sv
module i2s_slot_mux
   import i2s_tx_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int SLOT_W   = 32,
   localparam int BW      = log2_up(SLOTS_PER_FRAME * SLOT_W),
   localparam int SW      = log2_up(SAMPLE_W)
) (
   input  logic [BW-1:0]       bit_idx,
   input  logic [SAMPLE_W-1:0] left_w,
   input  logic [SAMPLE_W-1:0] right_w,
   output logic                chan,
   output logic                dout_n
);
   localparam logic [BW-1:0] SLOT_L = BW'(SLOT_W);
   localparam logic [BW-1:0] SAMP_L = BW'(SAMPLE_W);

   chan_e               ch;
   logic [BW-1:0]       pos;
   logic [BW-1:0]       sel;
   logic [SAMPLE_W-1:0] word;
   logic                in_field;

   always_comb begin
      ch       = (bit_idx >= SLOT_L) ? CH_RIGHT : CH_LEFT;
      pos      = (ch == CH_RIGHT) ? bit_idx - SLOT_L : bit_idx;
      word     = (ch == CH_RIGHT) ? right_w : left_w;
      in_field = (pos != '0) && (pos <= SAMP_L);
      sel      = SAMP_L - pos;
      dout_n   = in_field ? word[sel[SW-1:0]] : 1'b0;
   end

   assign chan = (ch == CH_RIGHT);
endmodule

// File: rtl/i2s_master_tx.sv
module i2s_master_tx
   import i2s_tx_pkg::*;
#(
   parameter int CLKS_PER_BIT = 64,
   parameter int SAMPLE_W     = 24,
   parameter int SLOT_W       = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic                s_valid,
   input  logic [SAMPLE_W-1:0] s_left,
   input  logic [SAMPLE_W-1:0] s_right,
   output logic                s_ready,
   output logic                mclk,
   output logic                bclk,
   output logic                lrclk,
   output logic                dout,
   output logic                frame_req
);
   localparam int PHW = log2_up(CLKS_PER_BIT);
   localparam int BW  = log2_up(SLOTS_PER_FRAME * SLOT_W);

   generate
      if (CLKS_PER_BIT < 8 || (CLKS_PER_BIT % 8) != 0) begin : g_bad_cpb
         $error("CLKS_PER_BIT must be a positive multiple of 8");
      end
      if (SAMPLE_W < 2 || SAMPLE_W >= SLOT_W) begin : g_bad_width
         $error("SAMPLE_W must be at least 2 and below SLOT_W");
      end
   endgenerate

   logic                run;
   logic [PHW-1:0]      phase;
   logic [BW-1:0]       bit_idx;
   logic                frame_start;
   logic                bclk_n;
   logic                mclk_n;
   logic                chan_n;
   logic                dout_n;
   logic [SAMPLE_W-1:0] act_left;
   logic [SAMPLE_W-1:0] act_right;
   logic                out_en;

   i2s_clkgen #(
      .CLKS_PER_BIT(CLKS_PER_BIT),
      .SLOT_W      (SLOT_W)
   ) u_clkgen (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .run        (run),
      .phase      (phase),
      .bit_idx    (bit_idx),
      .frame_start(frame_start),
      .bclk_n     (bclk_n),
      .mclk_n     (mclk_n)
   );

   i2s_sample_hold #(
      .SAMPLE_W(SAMPLE_W)
   ) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (frame_start),
      .s_valid  (s_valid),
      .s_left   (s_left),
      .s_right  (s_right),
      .s_ready  (s_ready),
      .act_left (act_left),
      .act_right(act_right)
   );

   i2s_slot_mux #(
      .SAMPLE_W(SAMPLE_W),
      .SLOT_W  (SLOT_W)
   ) u_mux (
      .bit_idx(bit_idx),
      .left_w (act_left),
      .right_w(act_right),
      .chan   (chan_n),
      .dout_n (dout_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_en    <= 1'b0;
         mclk      <= 1'b0;
         bclk      <= 1'b0;
         lrclk     <= 1'b0;
         dout      <= 1'b0;
         frame_req <= 1'b0;
      end else begin
         out_en    <= run;
         mclk      <= run && mclk_n;
         bclk      <= run && bclk_n;
         lrclk     <= run && chan_n;
         dout      <= run && dout_n;
         frame_req <= frame_start;
      end
   end

   p_lr_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_en && $past(out_en) && !$stable(lrclk)) |-> $fell(bclk));

   p_dout_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_en && $past(out_en) && !$stable(dout)) |-> $fell(bclk));

   p_req_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_req |=> !frame_req);

   p_req_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_req |-> !lrclk && !bclk && !mclk);

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |-> !mclk && !bclk && !lrclk && !dout && !frame_req);

   p_mclk_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bclk) |-> !mclk);
endmodule

// File: tb/sim_i2s_master_tx.sv
module sim_i2s_master_tx;
   localparam int CPB   = 16;
   localparam int FRAME = 64 * CPB;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        s_valid = 1'b0;
   logic [23:0] s_left = '0;
   logic [23:0] s_right = '0;
   logic        s_ready, mclk, bclk, lrclk, dout, frame_req;

   int checks = 0;
   int errors = 0;
   string tag = "R4";

   always #5 clk = ~clk;

   i2s_master_tx #(.CLKS_PER_BIT(CPB), .SAMPLE_W(24), .SLOT_W(32)) u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .s_valid(s_valid),
      .s_left(s_left), .s_right(s_right), .s_ready(s_ready), .mclk(mclk),
      .bclk(bclk), .lrclk(lrclk), .dout(dout), .frame_req(frame_req));

   // behavioural reference model
   logic        m_run, m_pend, e_en, e_frm;
   int          m_t, e_t, collisions;
   logic [23:0] m_hl, m_hr, m_al, m_ar, e_l, e_r;

   function automatic logic load_now(logic run, int t);
      return run && ((t % FRAME) == 0);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run <= 0; m_pend <= 0; m_t <= 0; e_en <= 0; e_t <= 0; e_frm <= 0;
         m_hl <= 0; m_hr <= 0; m_al <= 0; m_ar <= 0; e_l <= 0; e_r <= 0;
         collisions <= 0;
      end else begin
         logic ld, acc;
         ld  = load_now(m_run, m_t);
         acc = s_valid && (!m_pend || ld);
         e_en <= m_run; e_t <= m_t; e_l <= m_al; e_r <= m_ar; e_frm <= ld;
         if (ld && m_pend) begin m_al <= m_hl; m_ar <= m_hr; end
         if (acc) begin m_hl <= s_left; m_hr <= s_right; end
         if (acc && ld && m_pend) collisions <= collisions + 1;
         m_pend <= acc || (m_pend && !ld);
         m_run  <= enable;
         m_t    <= (m_run && enable) ? m_t + 1 : 0;
      end
   end

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         int ph, b, p;
         logic [23:0] w;
         logic xb, xm, xl, xd;
         ph = e_t % CPB; b = (e_t / CPB) % 64; p = b % 32;
         w  = (b >= 32) ? e_r : e_l;
         xb = e_en && (ph >= CPB / 2);
         xm = e_en && (((ph / (CPB / 8)) % 2) == 1);
         xl = e_en && (b >= 32);
         xd = e_en && (p >= 1) && (p <= 24) && w[24 - p];
         chk("R1", bclk, xb);
         chk("R2", mclk, xm);
         chk("R3", lrclk, xl);
         if (e_en && p >= 1 && p <= 24) chk({"R4/", tag}, dout, xd);
         else chk("R5", dout, xd);
         chk("R7", frame_req, e_en && e_frm);
         chk("R8", s_ready, !m_pend || load_now(m_run, m_t));
      end
   end

   task automatic send(input logic [23:0] l, input logic [23:0] r);
      logic rdy;
      @(negedge clk);
      s_valid = 1; s_left = l; s_right = r;
      forever begin
         #1 rdy = s_ready;
         @(posedge clk);
         if (rdy) break;
         @(negedge clk);
      end
      @(negedge clk);
      s_valid = 0;
   endtask

   task automatic wait_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait_cycles(4);
      rst_n = 1;
      #1;
      // R11: reset state
      chk("R11", mclk, 0); chk("R11", bclk, 0); chk("R11", lrclk, 0);
      chk("R11", dout, 0); chk("R11", frame_req, 0); chk("R11", s_ready, 1);
      send(24'hA5C30F, 24'h3C5A96);
      @(negedge clk) enable = 1;
      tag = "R9";                       // second frame repeats pair A
      wait_cycles(2 * FRAME + 40);
      tag = "R8";
      send(24'h800001, 24'h7FFFFE);
      wait_cycles(FRAME);
      tag = "R10";                      // second offer stalls until frame load
      send(24'h123456, 24'hFEDCBA);
      send(24'hFFFFFF, 24'h000000);
      wait_cycles(2 * FRAME + 100);
      checks++;
      if (collisions < 1) begin
         errors++;
         $display("FAIL R10: actual %0d collisions expected at least 1", collisions);
      end
      tag = "R11";
      while (!lrclk) @(negedge clk);
      wait_cycles(7 * CPB + 3);
      enable = 0;
      wait_cycles(4);
      chk("R11", bclk, 0); chk("R11", mclk, 0); chk("R11", lrclk, 0); chk("R11", dout, 0);
      send(24'h0F0F0F, 24'hF0F0F0);
      @(negedge clk) enable = 1;
      tag = "R1";                       // restart begins with a full bit
      wait_cycles(2 * FRAME + 20);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule